// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits behind a 32-bit host write port and in front of a bank of 128-bit control registers. The host can only write one dword at a time. The collector therefore gathers those dwords in a 128-bit staging buffer. It hands the assembled value to the register bank only once all four dwords of one register have arrived. The staging state is a 4-bit dword-valid mask plus the 16-byte-aligned base address of the register being gathered. The collector is empty when the mask is zero.

Two pointer-update registers per page bypass the normal completeness rule. A write to their highest dword always commits the whole register. The low 96 bits come from the buffer only if the buffer already holds all three low dwords of that same register; otherwise they are committed as zero. A write to one of their lower dwords is thrown away, and the buffer left untouched, if the buffer is busy with a different register. Two 32-bit registers per page are forwarded directly on a separate strobe and never enter the buffer. As a build option, a write to the second of these in page 0 empties the buffer.

The register file repeats every 0x2000 bytes. The address bits above bit 12 select the page, and bits 12:0 are the offset inside it. Every offset rule applies identically in every page.

Top module: `wide_write_collector`

## Requirements
- R1: An ordinary register commits only when all four of its dwords have been written, in any order. The dword at offset 4*i inside the 16-byte block lands in bits 32*i+31:32*i of the committed value.
- R2: `commit_valid` is high for exactly one cycle, in the cycle after the completing write. `commit_addr` carries the register base with bits 3:0 zero.
- R3: After any commit the collector is empty, so three further dwords of the same register do not commit.
- R4: A write to an ordinary register at a different base while the collector is occupied restarts gathering at the new base with only the new dword valid. Dwords gathered earlier are lost.
- R5: A write to the top dword (offset 0xC) of a pointer-update register, at block offsets 0x830 and 0xA10, always commits in the next cycle.
- R6: On that commit, bits 127:96 carry the written data. Bits 95:0 are the gathered dwords if dwords 0, 1 and 2 of the same register were present, and zero otherwise.
- R7: A write to dword 0, 1 or 2 of a pointer-update register while the collector holds a different register is dropped. No commit follows, and the gathered data and mask are unchanged.
- R8: The page is address bits ADDR_W-1:13. Pointer-update and direct offsets are recognised in every page, and the commit address keeps the page bits.
- R9: Writes to offsets 0x400 and 0x420 produce a one-cycle `direct_valid` with address and data in the next cycle. They never commit and never change gathered data.
- R10: With TIMER_CLEARS set (the default), a write to offset 0x420 in page 0 empties the collector. The same offset in any other page does not.
- R11: Reset holds both strobes low and leaves the collector empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host dword write strobe |
| wr_addr | input | ADDR_W | Byte address of the dword (bits 1:0 ignored) |
| wr_data | input | 32 | Write data |
| commit_valid | output | 1 | One-cycle commit of a full 128-bit register |
| commit_addr | output | ADDR_W | Aligned base address of the committed register |
| commit_data | output | 128 | Committed register value |
| direct_valid | output | 1 | One-cycle strobe for a direct 32-bit register |
| direct_addr | output | ADDR_W | Address of the direct register write |
| direct_data | output | 32 | Data of the direct register write |

## Verification
The assertions assume that the host drives `wr_valid` low during reset and that every address is dword-aligned. The bench keeps to both: it holds the port idle through reset and builds every address from a 16-byte base plus 4*lane. The stimulus sweeps all 24 dword orderings across several pages and all eight subsets of pre-gathered low dwords on both pointer-update registers in four pages. It also runs directed sequences for restart, drop, direct bypass and timer clearing. Each sequence is finished with writes whose expected commit exposes whatever state the earlier writes could have disturbed.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

    localparam int DW         = 32;
    localparam int LANES      = 4;
    localparam int REG_W      = DW * LANES;
    localparam int PAGE_SHIFT = 13;
    localparam int LANE_W     = $clog2(LANES);

    localparam logic [PAGE_SHIFT-1:0] OFF_DIRECT = 13'h400;
    localparam logic [PAGE_SHIFT-1:0] OFF_TIMER  = 13'h420;
    localparam logic [PAGE_SHIFT-1:0] OFF_PTR_A  = 13'h830;
    localparam logic [PAGE_SHIFT-1:0] OFF_PTR_B  = 13'hA10;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_PTR    = 2'd1,
        KIND_DIRECT = 2'd2
    } wkind_e;

    typedef struct packed {
        wkind_e              kind;
        logic [LANE_W-1:0]   lane;
        logic                clears;
    } wreq_t;

    function automatic wkind_e classify(input logic [PAGE_SHIFT-1:0] off);
        wkind_e k;
        if (off[PAGE_SHIFT-1:2] == OFF_DIRECT[PAGE_SHIFT-1:2] ||
            off[PAGE_SHIFT-1:2] == OFF_TIMER[PAGE_SHIFT-1:2])
            k = KIND_DIRECT;
        else if (off[PAGE_SHIFT-1:4] == OFF_PTR_A[PAGE_SHIFT-1:4] ||
                 off[PAGE_SHIFT-1:4] == OFF_PTR_B[PAGE_SHIFT-1:4])
            k = KIND_PTR;
        else
            k = KIND_PLAIN;
        return k;
    endfunction

    function automatic logic [LANES-1:0] lane_bit(input logic [LANE_W-1:0] l);
        return LANES'(1) << l;
    endfunction

endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
    import wwc_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter bit TIMER_CLEARS = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output wreq_t             req,
    output logic [ADDR_W-1:0] base
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [PAGE_SHIFT-1:0] off;
    logic [PAGE_W-1:0]     page;
    logic                  timer_hit;

    assign off  = addr[PAGE_SHIFT-1:0];
    assign page = addr[ADDR_W-1:PAGE_SHIFT];
    assign base = {addr[ADDR_W-1:4], 4'b0000};

    generate
        if (TIMER_CLEARS) begin : g_timer_clear
            assign timer_hit = (off[PAGE_SHIFT-1:2] == OFF_TIMER[PAGE_SHIFT-1:2]) &&
                               (page == '0);
        end else begin : g_timer_keep
            assign timer_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        req.kind   = classify(off);
        req.lane   = addr[3:2];
        req.clears = timer_hit;
    end
endmodule

// File: rtl/wwc_gather.sv
module wwc_gather
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  wreq_t             req,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DW-1:0]     req_data,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_base,
    output logic [REG_W-1:0]  fire_data,
    output logic              drop
);
    logic [LANES-1:0]  mask_q, mask_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [DW-1:0]     lane_q [LANES];
    logic [LANES-1:0]  lane_we;
    logic [REG_W-1:0]  merged;
    logic              occupied, same_reg, accept, low_full;
    logic [LANES-1:0]  sel;

    assign occupied = (mask_q != '0);
    assign same_reg = (base_q == req_base);
    assign sel      = lane_bit(req.lane);
    assign low_full = same_reg && (mask_q[LANES-2:0] == '1);

    always_comb begin
        mask_d  = mask_q;
        base_d  = base_q;
        accept  = 1'b0;
        drop    = 1'b0;
        fire    = 1'b0;
        if (req_valid) begin
            unique case (req.kind)
                KIND_PLAIN: begin
                    accept = 1'b1;
                    base_d = req_base;
                    mask_d = (occupied && !same_reg) ? sel : (mask_q | sel);
                    if (mask_d == '1) begin
                        fire   = 1'b1;
                        mask_d = '0;
                    end
                end
                KIND_PTR: begin
                    if (req.lane == LANE_W'(LANES-1)) begin
                        fire   = 1'b1;
                        mask_d = '0;
                        base_d = req_base;
                    end else if (occupied && !same_reg) begin
                        drop = 1'b1;
                    end else begin
                        accept = 1'b1;
                        base_d = req_base;
                        mask_d = mask_q | sel;
                    end
                end
                KIND_DIRECT: begin
                    if (req.clears) mask_d = '0;
                end
                default: ;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign lane_we[gi] = accept && sel[gi];
            always_ff @(posedge clk) begin
                if (rst)               lane_q[gi] <= '0;
                else if (lane_we[gi])  lane_q[gi] <= req_data;
            end
            if (gi == LANES - 1) begin : g_top
                assign merged[gi*DW +: DW] = sel[gi] ? req_data : lane_q[gi];
            end else begin : g_low
                always_comb begin
                    if (req.kind == KIND_PTR)
                        merged[gi*DW +: DW] = low_full ? lane_q[gi] : '0;
                    else
                        merged[gi*DW +: DW] = sel[gi] ? req_data : lane_q[gi];
                end
            end
        end
    endgenerate

    assign fire_base = req_base;
    assign fire_data = merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
        end else begin
            mask_q <= mask_d;
            base_q <= base_d;
        end
    end

    AST_EMPTY_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> (mask_q == '0)); // R3
    AST_DROP_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        drop |=> ($stable(mask_q) && $stable(base_q))); // R7
    AST_PLAIN_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        (fire && req.kind == KIND_PLAIN && occupied && same_reg) |->
            ($countones(mask_q | sel) == LANES)); // R1
endmodule

// File: rtl/wwc_out_stage.sv
module wwc_out_stage
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              c_fire,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [REG_W-1:0]  c_data,
    input  logic              d_fire,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DW-1:0]     d_data,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [REG_W-1:0]  commit_data,
    output logic              direct_valid,
    output logic [ADDR_W-1:0] direct_addr,
    output logic [DW-1:0]     direct_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_valid <= 1'b0;
            commit_addr  <= '0;
            commit_data  <= '0;
            direct_valid <= 1'b0;
            direct_addr  <= '0;
            direct_data  <= '0;
        end else begin
            commit_valid <= c_fire;
            direct_valid <= d_fire;
            if (c_fire) begin
                commit_addr <= c_addr;
                commit_data <= c_data;
            end
            if (d_fire) begin
                direct_addr <= d_addr;
                direct_data <= d_data;
            end
        end
    end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter bit TIMER_CLEARS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [127:0]      commit_data,
    output logic              direct_valid,
    output logic [ADDR_W-1:0] direct_addr,
    output logic [31:0]       direct_data
);
    wreq_t             req;
    logic [ADDR_W-1:0] req_base;
    logic              fire, drop, dfire;
    logic [ADDR_W-1:0] fire_base;
    logic [REG_W-1:0]  fire_data;

    wwc_decode #(.ADDR_W(ADDR_W), .TIMER_CLEARS(TIMER_CLEARS)) u_decode (
        .addr (wr_addr),
        .req  (req),
        .base (req_base)
    );

    wwc_gather #(.ADDR_W(ADDR_W)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .req_valid (wr_valid),
        .req       (req),
        .req_base  (req_base),
        .req_data  (wr_data),
        .fire      (fire),
        .fire_base (fire_base),
        .fire_data (fire_data),
        .drop      (drop)
    );

    assign dfire = wr_valid && (req.kind == KIND_DIRECT);

    wwc_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .c_fire       (fire),
        .c_addr       (fire_base),
        .c_data       (fire_data),
        .d_fire       (dfire),
        .d_addr       ({wr_addr[ADDR_W-1:2], 2'b00}),
        .d_data       (wr_data),
        .commit_valid (commit_valid),
        .commit_addr  (commit_addr),
        .commit_data  (commit_data),
        .direct_valid (direct_valid),
        .direct_addr  (direct_addr),
        .direct_data  (direct_data)
    );

    AST_COMMIT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> $past(wr_valid)); // R2
    AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (commit_addr[3:0] == 4'h0)); // R2
    AST_PTR_TOP_COMMITS: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && req.kind == KIND_PTR && wr_addr[3:2] == 2'b11) |=> commit_valid); // R5
    AST_DIRECT_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && req.kind == KIND_DIRECT) |=> (direct_valid && !commit_valid)); // R9
    AST_DROP_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        drop |=> !commit_valid); // R7
endmodule

// File: tb/wide_write_collector_test.sv
module wide_write_collector_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          commit_valid, direct_valid;
    logic [AW-1:0] commit_addr, direct_addr;
    logic [127:0]  commit_data;
    logic [31:0]   direct_data;

    wide_write_collector #(.ADDR_W(AW), .TIMER_CLEARS(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data),
        .direct_valid(direct_valid), .direct_addr(direct_addr), .direct_data(direct_data)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic          s_cv, s_dv;
    logic [AW-1:0] s_ca, s_da;
    logic [127:0]  s_cd;
    logic [31:0]   s_dd;

    function automatic logic [31:0] ldat(input logic [AW-1:0] b, input int lane, input int seed);
        return (32'(b) << 12) ^ (32'(lane) * 32'h01010101) ^ (32'(seed) * 32'h9E3779B1);
    endfunction

    function automatic logic [127:0] expv(input logic [AW-1:0] b, input int seed, input logic [3:0] m);
        logic [127:0] v = '0;
        for (int i = 0; i < 4; i++) if (m[i]) v[i*32 +: 32] = ldat(b, i, seed);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sample();
        s_cv = commit_valid; s_ca = commit_addr; s_cd = commit_data;
        s_dv = direct_valid; s_da = direct_addr; s_dd = direct_data;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        sample();
        wr_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(posedge clk); #1;
        sample();
    endtask

    task automatic wlane(input logic [AW-1:0] b, input int lane, input int seed);
        wr(b + AW'(4 * lane), ldat(b, lane, seed));
    endtask

    task automatic expect_commit(input string tag, input logic [AW-1:0] b, input logic [127:0] v);
        chk({tag, " valid"}, 128'(s_cv), 128'(1));
        chk({tag, " addr"}, 128'(s_ca), 128'(b));
        chk({tag, " data"}, s_cd, v);
    endtask

    task automatic expect_none(input string tag);
        chk({tag, " no commit"}, 128'(s_cv), 128'(0));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] a, b2;
        int seed = 1;
        rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1; sample();
        chk("R11 reset commit_valid", 128'(s_cv), 128'(0));
        chk("R11 reset direct_valid", 128'(s_dv), 128'(0));
        @(negedge clk); rst = 1'b0;
        idle();
        chk("R11 idle after reset", 128'(s_cv), 128'(0));

        // R1 R2 R8: all 24 lane orders, spread over pages
        begin
            int n = 0;
            for (int p0 = 0; p0 < 4; p0++)
            for (int p1 = 0; p1 < 4; p1++)
            for (int p2 = 0; p2 < 4; p2++)
            for (int p3 = 0; p3 < 4; p3++) begin
                int ord[4];
                if (p0 == p1 || p0 == p2 || p0 == p3 || p1 == p2 || p1 == p3 || p2 == p3) continue;
                ord = '{p0, p1, p2, p3};
                a = AW'(((n % 8) << 13) | (16'h0100 + 16 * n));
                seed++;
                for (int k = 0; k < 3; k++) begin
                    wlane(a, ord[k], seed);
                    expect_none("R1 partial");
                end
                wlane(a, ord[3], seed);
                expect_commit("R1 complete", a, expv(a, seed, 4'hF));
                idle();
                chk("R2 single pulse", 128'(s_cv), 128'(0));
                n++;
            end
        end

        // R3: after commit, collector empty
        a = 16'h2200; seed++;
        for (int k = 0; k < 4; k++) wlane(a, k, seed);
        expect_commit("R3 first", a, expv(a, seed, 4'hF));
        seed++;
        for (int k = 1; k < 4; k++) begin wlane(a, k, seed); expect_none("R3 refill"); end
        wlane(a, 0, seed);
        expect_commit("R3 second", a, expv(a, seed, 4'hF));

        // R4: restart on different ordinary register
        a = 16'h0300; b2 = 16'h0310; seed++;
        wlane(a, 0, seed); wlane(a, 1, seed);
        wlane(b2, 0, seed); expect_none("R4 restart");
        wlane(a, 2, seed); wlane(a, 3, seed); expect_none("R4 old lanes lost");
        wlane(a, 0, seed); expect_none("R4 rebuild");
        wlane(a, 1, seed);
        expect_commit("R4 rebuilt", a, expv(a, seed, 4'hF));

        // R5 R6 R8: pointer registers, all subsets of low lanes, pages 0..3
        for (int pg = 0; pg < 4; pg++)
        for (int r = 0; r < 2; r++)
        for (int sub = 0; sub < 8; sub++) begin
            a = AW'((pg << 13) | (r != 0 ? 16'h0A10 : 16'h0830));
            seed++;
            for (int k = 0; k < 3; k++) if (sub[k]) begin
                wlane(a, k, seed); expect_none("R6 low gather");
            end
            wlane(a, 3, seed);
            expect_commit("R5 R6 top commit", a, expv(a, seed, sub == 7 ? 4'hF : 4'h8));
        end

        // R7: pointer low write dropped while other register held
        a = 16'h0440; b2 = 16'h0830; seed++;
        wlane(a, 0, seed); wlane(a, 1, seed);
        wr(b2, 32'hDEAD0001); expect_none("R7 drop");
        wr(b2 + 16'd8, 32'hDEAD0002); expect_none("R7 drop lane2");
        wlane(a, 2, seed); wlane(a, 3, seed);
        expect_commit("R7 state kept", a, expv(a, seed, 4'hF));

        // R5 R3: pointer top while other register held commits zero fill, empties
        a = 16'h0450; seed++;
        wlane(a, 0, seed); wlane(a, 1, seed);
        wr(16'h0A1C, 32'h5A5A0003);
        expect_commit("R5 top over other", 16'h0A10, {32'h5A5A0003, 96'h0});
        wlane(a, 2, seed); wlane(a, 3, seed); expect_none("R3 emptied by ptr");

        // R9: direct registers bypass collector
        a = 16'h0460; seed++;
        wlane(a, 0, seed); wlane(a, 1, seed);
        wr(16'h4400, 32'h0BADF00D);
        expect_none("R9 direct");
        chk("R9 direct valid", 128'(s_dv), 128'(1));
        chk("R9 direct addr", 128'(s_da), 128'(16'h4400));
        chk("R9 direct data", 128'(s_dd), 128'(32'h0BADF00D));
        wr(16'h2420, 32'h12345678);
        chk("R9 R10 timer page1 direct", 128'(s_dv), 128'(1));
        wlane(a, 2, seed); wlane(a, 3, seed);
        expect_commit("R9 R10 collector intact", a, expv(a, seed, 4'hF));
        idle();
        chk("R9 direct pulse", 128'(s_dv), 128'(0));

        // R10: timer in page 0 clears collector
        a = 16'h0470; seed++;
        for (int k = 0; k < 3; k++) wlane(a, k, seed);
        wr(16'h0420, 32'h00000042);
        chk("R10 timer direct", 128'(s_dv), 128'(1));
        wlane(a, 3, seed); expect_none("R10 cleared");
        for (int k = 0; k < 2; k++) wlane(a, k, seed);
        expect_none("R10 partial");
        wlane(a, 2, seed);
        expect_commit("R10 regather", a, expv(a, seed, 4'hF));

        finish_run();
    end
endmodule